// File: doc/BRIEF.md
# Last-Branch Record Ring with Select Filter

This block keeps a circular history of the most recent taken branches seen by a core. Each record holds a source address, a target address and a small info field. A top-of-stack pointer always names the newest record, and software reads the history by age: age 0 is the newest record, age 1 the one before it, and so on. The classification of each branch into a type class, and the privilege ring of its target, arrive from the front end together with the event.

A 10-bit select register filters what is captured. Its low nine bits work in suppress mode: a set bit blocks branches whose target is in a given ring, or branches of a given class. The top bit switches the ring into call-stack mode. In that mode calls push a record and near returns pop the pointer, so the ring mirrors the live call chain. A debug-control pair enables recording and can arm a freeze on a performance-monitor interrupt. The freeze is never armed while call-stack mode is on. Software can wipe all records in one command and can load the pointer directly to restore a saved stack.

Top module: `brr_ring`

## Requirements
- R1: After reset the pointer `tos_q` is 0, `frozen` is 0, the select register is 0 and every record reads back as all zeros at every age.
- R2: In normal mode (select bit 9 clear) an accepted event advances `tos_q` by one modulo DEPTH and stores its source, target and info at the new pointer. The read port returns the record at index (`tos_q` − `rd_age`) & (DEPTH − 1).
- R3: Select bit 0 blocks events whose target ring (`ev_ring`) is 0. Select bit 1 blocks events whose target ring is 1, 2 or 3.
- R4: Class codes on `ev_cls` are 0 conditional, 1 relative call, 2 indirect call, 3 near return, 4 indirect jump, 5 relative jump and 6 far branch. Select bit 2+c blocks class c. Code 7 is reserved and is never recorded.
- R5: While `rec_en` is 0 no event changes the pointer or any record.
- R6: With `frz_on_irq` set and call-stack mode off, a `pmi` pulse sets `frozen`. While `frozen` is set no event is recorded. `frz_clr` clears `frozen`, and a `pmi` in the same cycle as `frz_clr` wins.
- R7: In call-stack mode an accepted relative or indirect call advances the pointer and writes the record. An accepted near return decrements the pointer and writes nothing. Any other accepted class leaves the pointer and the records unchanged.
- R8: While select bit 9 is set, `pmi` never sets `frozen`.
- R9: `wipe` zeroes the source, target and info of every record in one cycle and leaves `tos_q` unchanged. An event presented in the same cycle is dropped.
- R10: `tos_wr` loads `tos_wdata` into the pointer. An event presented in the same cycle is dropped.
- R11: `sel_wr` loads all 10 bits of the select register. An event in the same cycle is filtered by the previous select value.
- R12: After more than DEPTH accepted events the oldest records are overwritten, and ages 0 to DEPTH−1 return the DEPTH newest events, newest first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | A taken-branch event is present |
| ev_cls | input | 3 | Branch class code of the event |
| ev_ring | input | 2 | Privilege ring of the branch target |
| ev_src | input | ADDR_W | Branch source address |
| ev_dst | input | ADDR_W | Branch target address |
| ev_info | input | INFO_W | Info field stored with the record |
| sel_wr | input | 1 | Write strobe for the select register |
| sel_wdata | input | 10 | New select value |
| rec_en | input | 1 | Recording enable |
| frz_on_irq | input | 1 | Arm freeze on performance-monitor interrupt |
| pmi | input | 1 | Performance-monitor interrupt pulse |
| frz_clr | input | 1 | Software clear of the freeze |
| frozen | output | 1 | Recording is frozen |
| wipe | input | 1 | Zero all records |
| tos_wr | input | 1 | Load strobe for the pointer |
| tos_wdata | input | log2(DEPTH) | Pointer value to load |
| tos_q | output | log2(DEPTH) | Current pointer (newest record) |
| rd_age | input | log2(DEPTH) | Age of the record to read |
| rd_src | output | ADDR_W | Source of the record at that age |
| rd_dst | output | ADDR_W | Target of the record at that age |
| rd_info | output | INFO_W | Info of the record at that age |

## Verification
The properties assume that reset is held for at least two clock edges, so that every `$past` term refers to a defined pointer. They also assume that all control inputs change only between edges. They place no limit on how `wipe`, `tos_wr`, `pmi` and events overlap, because the design gives each collision a fixed priority. The bench drives every input half a cycle away from the rising edge and holds reset for three cycles. It also makes these collisions on purpose: an event with a wipe, an event with a pointer load, an event with a select write, and a `pmi` with `frz_clr`.

// File: rtl/brr_pkg.sv
package brr_pkg;

    parameter int ADDR_W = 16;
    parameter int INFO_W = 4;
    parameter int SEL_W  = 10;
    parameter int RING_W = 2;

    localparam int RING0_BIT = 0;
    localparam int RINGN_BIT = 1;
    localparam int CLS_BASE  = 2;
    localparam int NUM_CLS   = 7;
    localparam int CS_BIT    = 9;

    typedef enum logic [2:0] {
        BR_COND  = 3'd0,
        BR_RCALL = 3'd1,
        BR_ICALL = 3'd2,
        BR_NRET  = 3'd3,
        BR_IJMP  = 3'd4,
        BR_RJMP  = 3'd5,
        BR_FAR   = 3'd6,
        BR_RSVD  = 3'd7
    } br_cls_e;

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [INFO_W-1:0] info;
    } br_rec_t;

    // Suppress-mode decode: returns 1 when the select value blocks the event.
    function automatic logic sel_blocks(input logic [SEL_W-1:0] sel,
                                        input br_cls_e cls,
                                        input logic [RING_W-1:0] ring);
        logic [NUM_CLS-1:0] cmask;
        logic hit;
        cmask = sel[CLS_BASE +: NUM_CLS];
        hit = (ring == '0) ? sel[RING0_BIT] : sel[RINGN_BIT];
        if (cls == BR_RSVD)
            hit = 1'b1;
        else
            hit = hit | cmask[cls];
        return hit;
    endfunction

    function automatic logic is_call(input br_cls_e cls);
        return (cls == BR_RCALL) || (cls == BR_ICALL);
    endfunction

endpackage

// File: rtl/brr_filter.sv
module brr_filter
    import brr_pkg::*;
(
    input  logic [SEL_W-1:0]  sel_q,
    input  logic              ev_valid,
    input  br_cls_e           ev_cls,
    input  logic [RING_W-1:0] ev_ring,
    input  logic              rec_en,
    input  logic              frozen,
    input  logic              hold,
    output logic              push,
    output logic              pop
);
    logic accept;
    logic cs_mode;

    always_comb begin
        cs_mode = sel_q[CS_BIT];
        accept  = ev_valid && rec_en && !frozen && !hold
                  && !sel_blocks(sel_q, ev_cls, ev_ring);
        if (cs_mode) begin
            push = accept && is_call(ev_cls);
            pop  = accept && (ev_cls == BR_NRET);
        end else begin
            push = accept;
            pop  = 1'b0;
        end
    end
endmodule

// File: rtl/brr_freeze.sv
module brr_freeze (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic pmi,
    input  logic clr,
    output logic frozen
);
    always_ff @(posedge clk) begin
        if (rst)
            frozen <= 1'b0;
        else if (arm && pmi)
            frozen <= 1'b1;
        else if (clr)
            frozen <= 1'b0;
    end
endmodule

// File: rtl/brr_tos.sv
module brr_tos #(
    parameter int DEPTH = 8,
    localparam int IDXW = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [IDXW-1:0] load_val,
    input  logic            push,
    input  logic            pop,
    output logic [IDXW-1:0] tos_q,
    output logic [IDXW-1:0] wr_idx
);
    assign wr_idx = tos_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst)
            tos_q <= '0;
        else if (load)
            tos_q <= load_val;
        else if (push)
            tos_q <= tos_q + 1'b1;
        else if (pop)
            tos_q <= tos_q - 1'b1;
    end
endmodule

// File: rtl/brr_store.sv
module brr_store
    import brr_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDXW = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wipe,
    input  logic            we,
    input  logic [IDXW-1:0] widx,
    input  br_rec_t         wrec,
    input  logic [IDXW-1:0] ridx,
    output br_rec_t         rrec
);
    br_rec_t rows [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        br_rec_t q;
        always_ff @(posedge clk) begin
            if (rst || wipe)
                q <= '0;
            else if (we && (widx == IDXW'(e)))
                q <= wrec;
        end
        assign rows[e] = q;
    end

    assign rrec = rows[ridx];
endmodule

// File: rtl/brr_ring.sv
module brr_ring
    import brr_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDXW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_valid,
    input  logic [2:0]        ev_cls,
    input  logic [RING_W-1:0] ev_ring,
    input  logic [ADDR_W-1:0] ev_src,
    input  logic [ADDR_W-1:0] ev_dst,
    input  logic [INFO_W-1:0] ev_info,
    input  logic              sel_wr,
    input  logic [SEL_W-1:0]  sel_wdata,
    input  logic              rec_en,
    input  logic              frz_on_irq,
    input  logic              pmi,
    input  logic              frz_clr,
    output logic              frozen,
    input  logic              wipe,
    input  logic              tos_wr,
    input  logic [IDXW-1:0]   tos_wdata,
    output logic [IDXW-1:0]   tos_q,
    input  logic [IDXW-1:0]   rd_age,
    output logic [ADDR_W-1:0] rd_src,
    output logic [ADDR_W-1:0] rd_dst,
    output logic [INFO_W-1:0] rd_info
);
    if (!(DEPTH == 4 || DEPTH == 8 || DEPTH == 16 || DEPTH == 32)) begin : g_bad_depth
        $error("brr_ring: DEPTH must be 4, 8, 16 or 32");
    end

    logic [SEL_W-1:0] sel_q;
    logic             push;
    logic             pop;
    logic             hold;
    logic [IDXW-1:0]  wr_idx;
    logic [IDXW-1:0]  rd_idx;
    br_rec_t          new_rec;
    br_rec_t          rd_rec;

    always_ff @(posedge clk) begin
        if (rst)
            sel_q <= '0;
        else if (sel_wr)
            sel_q <= sel_wdata;
    end

    assign hold    = wipe || tos_wr;
    assign new_rec = '{src: ev_src, dst: ev_dst, info: ev_info};
    assign rd_idx  = tos_q - rd_age;

    brr_filter u_flt (
        .sel_q    (sel_q),
        .ev_valid (ev_valid),
        .ev_cls   (br_cls_e'(ev_cls)),
        .ev_ring  (ev_ring),
        .rec_en   (rec_en),
        .frozen   (frozen),
        .hold     (hold),
        .push     (push),
        .pop      (pop)
    );

    brr_freeze u_frz (
        .clk    (clk),
        .rst    (rst),
        .arm    (frz_on_irq && !sel_q[CS_BIT]),
        .pmi    (pmi),
        .clr    (frz_clr),
        .frozen (frozen)
    );

    brr_tos #(.DEPTH(DEPTH)) u_tos (
        .clk      (clk),
        .rst      (rst),
        .load     (tos_wr),
        .load_val (tos_wdata),
        .push     (push),
        .pop      (pop),
        .tos_q    (tos_q),
        .wr_idx   (wr_idx)
    );

    brr_store #(.DEPTH(DEPTH)) u_st (
        .clk  (clk),
        .rst  (rst),
        .wipe (wipe),
        .we   (push),
        .widx (wr_idx),
        .wrec (new_rec),
        .ridx (rd_idx),
        .rrec (rd_rec)
    );

    assign rd_src  = rd_rec.src;
    assign rd_dst  = rd_rec.dst;
    assign rd_info = rd_rec.info;
endmodule

// File: rtl/brr_ring_chk.sv
module brr_ring_chk
    import brr_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IDXW = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              rst,
    input logic              push,
    input logic              pop,
    input logic [IDXW-1:0]   tos_q,
    input logic              frozen,
    input logic [SEL_W-1:0]  sel_q,
    input logic              frz_clr,
    input logic              rec_en,
    input logic              wipe,
    input logic              tos_wr,
    input logic [IDXW-1:0]   tos_wdata,
    input logic [ADDR_W-1:0] rd_src,
    input logic [ADDR_W-1:0] rd_dst,
    input logic [INFO_W-1:0] rd_info
);
    assert_push_adv_R2: assert property (@(posedge clk) disable iff (rst)
        push |=> tos_q == IDXW'($past(tos_q) + 1'b1));

    assert_ret_pop_R7: assert property (@(posedge clk) disable iff (rst)
        pop |=> tos_q == IDXW'($past(tos_q) - 1'b1));

    assert_no_rec_R5: assert property (@(posedge clk) disable iff (rst)
        !rec_en |-> !push && !pop);

    assert_frz_blocks_R6: assert property (@(posedge clk) disable iff (rst)
        frozen |-> !push && !pop);

    assert_frz_hold_R6: assert property (@(posedge clk) disable iff (rst)
        frozen && !frz_clr |=> frozen);

    assert_cs_nofrz_R8: assert property (@(posedge clk) disable iff (rst)
        sel_q[CS_BIT] && !frozen |=> !frozen);

    assert_wipe_zero_R9: assert property (@(posedge clk) disable iff (rst)
        wipe |=> rd_src == '0 && rd_dst == '0 && rd_info == '0);

    assert_tos_load_R10: assert property (@(posedge clk) disable iff (rst)
        tos_wr |=> tos_q == $past(tos_wdata));

    assert_tos_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !push && !pop && !tos_wr |=> $stable(tos_q));

    assert_hold_drop_R9: assert property (@(posedge clk) disable iff (rst)
        wipe || tos_wr |-> !push && !pop);
endmodule

bind brr_ring brr_ring_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .pop       (pop),
    .tos_q     (tos_q),
    .frozen    (frozen),
    .sel_q     (sel_q),
    .frz_clr   (frz_clr),
    .rec_en    (rec_en),
    .wipe      (wipe),
    .tos_wr    (tos_wr),
    .tos_wdata (tos_wdata),
    .rd_src    (rd_src),
    .rd_dst    (rd_dst),
    .rd_info   (rd_info)
);

// File: tb/tb_brr_ring.sv
`timescale 1ns/100ps
module tb_brr_ring;
    import brr_pkg::*;

    localparam int DEPTH = 8;
    localparam int IDXW  = $clog2(DEPTH);
    localparam int MSK   = DEPTH - 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ev_valid = 1'b0;
    logic [2:0]        ev_cls = '0;
    logic [RING_W-1:0] ev_ring = '0;
    logic [ADDR_W-1:0] ev_src = '0;
    logic [ADDR_W-1:0] ev_dst = '0;
    logic [INFO_W-1:0] ev_info = '0;
    logic              sel_wr = 1'b0;
    logic [SEL_W-1:0]  sel_wdata = '0;
    logic              rec_en = 1'b1;
    logic              frz_on_irq = 1'b0;
    logic              pmi = 1'b0;
    logic              frz_clr = 1'b0;
    logic              frozen;
    logic              wipe = 1'b0;
    logic              tos_wr = 1'b0;
    logic [IDXW-1:0]   tos_wdata = '0;
    logic [IDXW-1:0]   tos_q;
    logic [IDXW-1:0]   rd_age = '0;
    logic [ADDR_W-1:0] rd_src;
    logic [ADDR_W-1:0] rd_dst;
    logic [INFO_W-1:0] rd_info;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    int m_tos = 0;
    int m_sel = 0;
    int m_frozen = 0;
    int m_src [DEPTH];
    int m_dst [DEPTH];
    int m_info [DEPTH];

    always #2 clk = ~clk;

    brr_ring #(.DEPTH(DEPTH)) dut (.*);

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected next state from the requirements, using the inputs now applied.
    task automatic model_step();
        int blk;
        int acc;
        int cs;
        int c;
        int cb;
        c  = int'(ev_cls);
        cs = (m_sel >> 9) & 1;
        blk = (ev_ring == 0) ? (m_sel & 1) : ((m_sel >> 1) & 1);
        if (c == 7) blk = 1;
        else if (((m_sel >> (2 + c)) & 1) != 0) blk = 1;
        acc = (ev_valid && rec_en && m_frozen == 0 && !wipe && !tos_wr && blk == 0) ? 1 : 0;
        if (wipe) begin
            for (int i = 0; i < DEPTH; i++) begin
                m_src[i] = 0; m_dst[i] = 0; m_info[i] = 0;
            end
        end
        if (tos_wr) m_tos = int'(tos_wdata);
        cb = (c == 1 || c == 2) ? 1 : 0;
        if (acc == 1) begin
            if (cs == 0 || cb == 1) begin
                m_tos = (m_tos + 1) & MSK;
                m_src[m_tos]  = int'(ev_src);
                m_dst[m_tos]  = int'(ev_dst);
                m_info[m_tos] = int'(ev_info);
            end else if (c == 3) begin
                m_tos = (m_tos - 1) & MSK;
            end
        end
        if (pmi && frz_on_irq && cs == 0) m_frozen = 1;
        else if (frz_clr) m_frozen = 0;
        if (sel_wr) m_sel = int'(sel_wdata);
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        ev_valid = 0; pmi = 0; frz_clr = 0; wipe = 0; tos_wr = 0; sel_wr = 0;
    endtask

    task automatic set_ev(input int cls, input int ring, input int k);
        ev_valid = 1;
        ev_cls   = 3'(cls);
        ev_ring  = 2'(ring);
        ev_src   = ADDR_W'(k);
        ev_dst   = ADDR_W'(k ^ 16'h5a5a);
        ev_info  = INFO_W'(k);
    endtask

    task automatic send(input int cls, input int ring, input int k);
        set_ev(cls, ring, k);
        tick();
    endtask

    task automatic wr_sel(input int v);
        sel_wr = 1; sel_wdata = SEL_W'(v);
        tick();
    endtask

    task automatic check_all(input string tag);
        int idx;
        chk({tag, " tos"}, int'(tos_q), m_tos);
        chk({tag, " frozen"}, int'(frozen), m_frozen);
        for (int a = 0; a < DEPTH; a++) begin
            rd_age = IDXW'(a);
            #0.1;
            idx = (m_tos - a) & MSK;
            chk({tag, " src"}, int'(rd_src), m_src[idx]);
            chk({tag, " dst"}, int'(rd_dst), m_dst[idx]);
            chk({tag, " info"}, int'(rd_info), m_info[idx]);
        end
        rd_age = '0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int k;
        for (int i = 0; i < DEPTH; i++) begin
            m_src[i] = 0; m_dst[i] = 0; m_info[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1: reset state
        check_all("R1 reset");

        // R3 R4 R2: sweep every suppress pattern with every class and ring
        k = 1;
        for (int s = 0; s < 512; s++) begin
            wr_sel(s);
            for (int c = 0; c < 8; c++) begin
                for (int r = 0; r < 4; r++) begin
                    send(c, r, k);
                    k = (k + 1) & 16'hffff;
                    chk("R3 R4 R2 sweep tos", int'(tos_q), m_tos);
                    chk("R3 R4 R2 sweep age0 src", int'(rd_src), m_src[m_tos]);
                end
            end
        end
        check_all("R2 after sweep");

        // R12: wrap, newest first
        wr_sel(0);
        for (int n = 0; n < 11; n++) send(n % 7, n % 4, 16'h1000 + n);
        for (int a = 0; a < DEPTH; a++) begin
            rd_age = IDXW'(a);
            #0.1;
            chk("R12 wrap age order", int'(rd_src), 16'h1000 + 10 - a);
        end
        rd_age = '0;
        check_all("R12 wrap");

        // R5: recording disabled
        rec_en = 0;
        send(0, 0, 16'h2222);
        check_all("R5 rec_en low");
        rec_en = 1;

        // R6: freeze on interrupt
        frz_on_irq = 1;
        pmi = 1;
        tick();
        chk("R6 frozen set", int'(frozen), 1);
        send(5, 3, 16'h3333);
        check_all("R6 frozen ignores");
        frz_clr = 1;
        tick();
        chk("R6 frozen cleared", int'(frozen), 0);
        send(5, 3, 16'h3334);
        chk("R6 records after clear", int'(rd_src), 16'h3334);
        pmi = 1; frz_clr = 1;
        tick();
        chk("R6 pmi beats clear", int'(frozen), 1);
        frz_clr = 1;
        tick();
        check_all("R6 final");

        // R8: call-stack mode disarms the freeze
        wr_sel(10'h200);
        pmi = 1;
        tick();
        chk("R8 no freeze in call-stack", int'(frozen), 0);

        // R10 + R7: call-stack push/pop
        tos_wdata = 3'd2; tos_wr = 1;
        tick();
        chk("R10 tos load", int'(tos_q), 2);
        send(1, 0, 16'hA0A0);
        send(2, 1, 16'hB0B0);
        chk("R7 two calls", int'(tos_q), 4);
        send(3, 1, 16'hC0C0);
        chk("R7 return pops", int'(tos_q), 3);
        chk("R7 return writes nothing", int'(rd_src), 16'hA0A0);
        send(0, 1, 16'hD0D0);
        send(6, 0, 16'hD0D1);
        chk("R7 other class ignored", int'(tos_q), 3);
        send(1, 0, 16'hE0E0);
        chk("R7 call after return", int'(tos_q), 4);
        chk("R7 age0 src", int'(rd_src), 16'hE0E0);
        rd_age = 1; #0.1;
        chk("R7 age1 src", int'(rd_src), 16'hA0A0);
        rd_age = 0;
        check_all("R7 call-stack");
        frz_on_irq = 0;

        // R11: select write and event in the same cycle use the old select
        wr_sel(0);
        sel_wr = 1; sel_wdata = 10'h004;
        set_ev(0, 0, 16'h4444);
        tick();
        chk("R11 old select used", int'(rd_src), 16'h4444);
        send(0, 0, 16'h4445);
        chk("R11 new select blocks", int'(rd_src), 16'h4444);
        check_all("R11");

        // R10: load with a colliding event
        wr_sel(0);
        tos_wdata = 3'd6; tos_wr = 1;
        set_ev(4, 2, 16'h5555);
        tick();
        chk("R10 load drops event", int'(tos_q), 6);
        check_all("R10 collide");

        // R9: wipe with a colliding event
        set_ev(4, 2, 16'h6666);
        wipe = 1;
        tick();
        chk("R9 tos kept", int'(tos_q), 6);
        for (int a = 0; a < DEPTH; a++) begin
            rd_age = IDXW'(a);
            #0.1;
            chk("R9 wipe src", int'(rd_src), 0);
            chk("R9 wipe dst", int'(rd_dst), 0);
            chk("R9 wipe info", int'(rd_info), 0);
        end
        rd_age = '0;
        send(2, 0, 16'h7777);
        check_all("R9 after wipe");

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule